// File: doc/BRIEF.md
# Shift-Add Matrix-Vector Reduction Engine

This block multiplies a small integer matrix by a vector without using a multiplier. Each product is split into shifted copies of the matrix element, one copy for every set bit of the matching vector operand. Each copy becomes a keyed partial term whose key is the row index. The terms are placed in a shared pool. Two adders then repeatedly take two terms with the same key out of the pool and return their sum as one term. This continues until every row holds at most one term. That term is the row's dot product.

The host writes matrix elements and vector operands through a load port while the engine is idle, then pulses `start`. The engine runs a map phase, a reduce phase and an emit phase. It then streams one (row, sum) result per cycle in ascending row order and returns to idle. The operands are kept between runs, so a later start repeats the product on the same data unless the host reloads it.

Top module: `skadd_engine`

## Requirements
- R1: While `busy` is low, a cycle with `ld_en` high stores `ld_data`. With `ld_sel`=1 it goes to matrix element (`ld_row`,`ld_col`); with `ld_sel`=0 it goes to vector operand `ld_col`. While `busy` is high, load cycles are ignored.
- R2: A `start` pulse while `busy` is low raises `busy` in the following cycle. A `start` while `busy` is high is ignored and does not add another result stream.
- R3: Each result equals the exact unsigned sum over j of m[row][j]*v[j]. The result uses an accumulator width of 2*DW+log2(COLS) bits, and no addition ever overflows that width.
- R4: A zero matrix element or a zero vector operand contributes no term to the pool. A row with no terms reports a sum of zero.
- R5: For a non-zero element m and operand v, the mapper places one term m<<b in the pool for every bit b that is set in v.
- R6: Each run yields exactly ROWS result cycles on `out_valid`. The rows are consecutive and start at row 0. `busy` stays high until after the last result.
- R7: In one cycle, the two adders are given two disjoint pairs of pool entries. Every pair is two distinct valid entries that carry the same key.
- R8: Results are streamed only once no key holds more than one term and no addition is still in flight.
- R9: After reset, `busy` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 1 | 1 = matrix element, 0 = vector operand |
| ld_row | input | RW | Matrix row index for a load |
| ld_col | input | CW | Column or vector index for a load |
| ld_data | input | DW | Unsigned value to store |
| start | input | 1 | Begin a computation |
| busy | output | 1 | Run in progress, including the result stream |
| out_valid | output | 1 | Result present on `out_row`/`out_sum` |
| out_row | output | RW | Row of the current result |
| out_sum | output | AW | Dot product of that row |

## Verification
The checker examines dispatch on every cycle. It confirms that the two adders always receive disjoint same-key pairs of valid entries and that no adder sum carries out of the accumulator. It also checks that the mapper never writes a zero term, that the stream begins only after the pool has settled, and that stream rows start at zero and step by one. The numeric correctness of the sums can only be shown by the bench's scenarios. The same holds for the rule that loads and starts are ignored while busy, and for the all-zero row and saturated-operand cases. The bench compares those scenarios against products it computes itself.

// File: rtl/skadd_pkg.sv
package skadd_pkg;
  localparam int NADD = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_MAP  = 2'd1,
    PH_RED  = 2'd2,
    PH_EMIT = 2'd3
  } phase_e;
endpackage

// File: rtl/skadd_mapper.sv
// Walks every (row, column, bit) position and emits the shifted copy of the
// matrix element when the vector operand has that bit set (R5, R4).
module skadd_mapper #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 4,
  parameter int RW   = 2,
  parameter int CW   = 2,
  parameter int BW   = 2,
  parameter int AW   = 10,
  parameter int SW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] m_elem,
  input  logic [DW-1:0] v_elem,
  output logic [RW-1:0] rd_row,
  output logic [CW-1:0] rd_col,
  output logic          wr_en,
  output logic [SW-1:0] wr_slot,
  output logic [RW-1:0] wr_key,
  output logic [AW-1:0] wr_val,
  output logic          done
);
  logic          act_q, act_d;
  logic [RW-1:0] i_q, i_d;
  logic [CW-1:0] j_q, j_d;
  logic [BW-1:0] b_q, b_d;
  logic          last_i, last_j, last_b;
  int            slot_int;

  assign last_i = (i_q == RW'(ROWS - 1));
  assign last_j = (j_q == CW'(COLS - 1));
  assign last_b = (b_q == BW'(DW - 1));

  always_comb begin
    act_d = act_q;
    i_d   = i_q;
    j_d   = j_q;
    b_d   = b_q;
    if (go) begin
      act_d = 1'b1;
      i_d   = '0;
      j_d   = '0;
      b_d   = '0;
    end else if (act_q) begin
      b_d = last_b ? '0 : b_q + 1'b1;
      if (last_b) begin
        j_d = last_j ? '0 : j_q + 1'b1;
        if (last_j) begin
          i_d = last_i ? '0 : i_q + 1'b1;
          if (last_i) act_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      i_q   <= '0;
      j_q   <= '0;
      b_q   <= '0;
    end else begin
      act_q <= act_d;
      i_q   <= i_d;
      j_q   <= j_d;
      b_q   <= b_d;
    end
  end

  assign rd_row   = i_q;
  assign rd_col   = j_q;
  assign slot_int = (int'(i_q) * COLS + int'(j_q)) * DW + int'(b_q);
  assign wr_slot  = SW'(slot_int);
  assign wr_key   = i_q;
  assign wr_en    = act_q && (m_elem != '0) && v_elem[b_q];
  assign wr_val   = AW'(m_elem) << b_q;
  assign done     = act_q && last_i && last_j && last_b;
endmodule

// File: rtl/skadd_pool.sv
// Keyed term storage. Slots are filled by the mapper, emptied by dispatch and
// refilled by adder write-back.
module skadd_pool #(
  parameter int NSLOT = 64,
  parameter int NADD  = 2,
  parameter int RW    = 2,
  parameter int AW    = 10,
  parameter int SW    = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      wr_en,
  input  logic [SW-1:0]             wr_slot,
  input  logic [RW-1:0]             wr_key,
  input  logic [AW-1:0]             wr_val,
  input  logic [NADD-1:0]           take_en,
  input  logic [NADD-1:0][SW-1:0]   take_a,
  input  logic [NADD-1:0][SW-1:0]   take_b,
  input  logic [NADD-1:0]           wb_en,
  input  logic [NADD-1:0][SW-1:0]   wb_slot,
  input  logic [NADD-1:0][AW-1:0]   wb_val,
  output logic [NSLOT-1:0]          valid_o,
  output logic [NSLOT-1:0][RW-1:0]  key_o,
  output logic [NSLOT-1:0][AW-1:0]  val_o
);
  logic [NSLOT-1:0]         valid_q, valid_d;
  logic [NSLOT-1:0][RW-1:0] key_q, key_d;
  logic [NSLOT-1:0][AW-1:0] val_q, val_d;

  always_comb begin
    valid_d = valid_q;
    key_d   = key_q;
    val_d   = val_q;
    if (clr) begin
      valid_d = '0;
    end else begin
      if (wr_en) begin
        valid_d[wr_slot] = 1'b1;
        key_d[wr_slot]   = wr_key;
        val_d[wr_slot]   = wr_val;
      end
      for (int k = 0; k < NADD; k++) begin
        if (take_en[k]) begin
          valid_d[take_a[k]] = 1'b0;
          valid_d[take_b[k]] = 1'b0;
        end
        if (wb_en[k]) begin
          valid_d[wb_slot[k]] = 1'b1;
          val_d[wb_slot[k]]   = wb_val[k];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    key_q <= key_d;
    val_q <= val_d;
  end

  assign valid_o = valid_q;
  assign key_o   = key_q;
  assign val_o   = val_q;
endmodule

// File: rtl/skadd_dispatch.sv
// Finds same-key pairs in the pool and hands up to NADD of them, on distinct
// keys, to registered adders whose sums are written back the next cycle.
module skadd_dispatch #(
  parameter int ROWS  = 4,
  parameter int NSLOT = 64,
  parameter int NADD  = 2,
  parameter int RW    = 2,
  parameter int AW    = 10,
  parameter int SW    = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enable,
  input  logic [NSLOT-1:0]          valid,
  input  logic [NSLOT-1:0][RW-1:0]  key,
  input  logic [NSLOT-1:0][AW-1:0]  val,
  output logic [NADD-1:0]           take_en,
  output logic [NADD-1:0][SW-1:0]   take_a,
  output logic [NADD-1:0][SW-1:0]   take_b,
  output logic [NADD-1:0]           wb_en,
  output logic [NADD-1:0][SW-1:0]   wb_slot,
  output logic [NADD-1:0][AW-1:0]   wb_val,
  output logic                      pair_any,
  output logic                      inflight
);
  logic [ROWS-1:0]         has1, has_pair;
  logic [ROWS-1:0][SW-1:0] first_s, second_s;
  logic [NADD-1:0]         ad_busy_q;
  logic [NADD-1:0][SW-1:0] ad_slot_q;
  logic [NADD-1:0][AW-1:0] ad_sum_q;

  // per-key search for the two lowest valid slots
  always_comb begin
    has1     = '0;
    has_pair = '0;
    first_s  = '0;
    second_s = '0;
    for (int r = 0; r < ROWS; r++) begin
      for (int s = 0; s < NSLOT; s++) begin
        if (valid[s] && (key[s] == RW'(r))) begin
          if (!has1[r]) begin
            has1[r]    = 1'b1;
            first_s[r] = SW'(s);
          end else if (!has_pair[r]) begin
            has_pair[r] = 1'b1;
            second_s[r] = SW'(s);
          end
        end
      end
    end
  end

  // lowest keys with a pair go to adder 0, 1, ...
  always_comb begin
    int cnt;
    cnt     = 0;
    take_en = '0;
    take_a  = '0;
    take_b  = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (enable && has_pair[r] && (cnt < NADD)) begin
        take_en[cnt] = 1'b1;
        take_a[cnt]  = first_s[r];
        take_b[cnt]  = second_s[r];
        cnt          = cnt + 1;
      end
    end
  end

  for (genvar k = 0; k < NADD; k++) begin : g_adder
    logic [AW-1:0] sum_d;
    assign sum_d = val[take_a[k]] + val[take_b[k]];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ad_busy_q[k] <= 1'b0;
      else        ad_busy_q[k] <= take_en[k];
    end

    always_ff @(posedge clk) begin
      if (take_en[k]) begin
        ad_slot_q[k] <= take_a[k];
        ad_sum_q[k]  <= sum_d;
      end
    end
  end

  assign wb_en    = ad_busy_q;
  assign wb_slot  = ad_slot_q;
  assign wb_val   = ad_sum_q;
  assign pair_any = |has_pair;
  assign inflight = |ad_busy_q;
endmodule

// File: rtl/skadd_engine.sv
module skadd_engine #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 4,
  localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW    = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int BW    = (DW > 1) ? $clog2(DW) : 1,
  localparam int AW    = 2 * DW + CW,
  localparam int NSLOT = ROWS * COLS * DW,
  localparam int SW    = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic          ld_sel,
  input  logic [RW-1:0] ld_row,
  input  logic [CW-1:0] ld_col,
  input  logic [DW-1:0] ld_data,
  input  logic          start,
  output logic          busy,
  output logic          out_valid,
  output logic [RW-1:0] out_row,
  output logic [AW-1:0] out_sum
);
  import skadd_pkg::*;

  logic [DW-1:0] mat_q [ROWS][COLS];
  logic [DW-1:0] vec_q [COLS];

  phase_e        phase_q, phase_d;
  logic [RW-1:0] row_q, row_d;
  logic          ov_q, ov_d;
  logic [RW-1:0] orow_q, orow_d;
  logic [AW-1:0] osum_q, osum_d;

  logic          go;
  logic          map_done, map_wr;
  logic [RW-1:0] map_row, map_key;
  logic [CW-1:0] map_col;
  logic [SW-1:0] map_slot;
  logic [AW-1:0] map_val;

  logic [NSLOT-1:0]         pool_valid;
  logic [NSLOT-1:0][RW-1:0] pool_key;
  logic [NSLOT-1:0][AW-1:0] pool_val;

  logic [NADD-1:0]         take_en, wb_en;
  logic [NADD-1:0][SW-1:0] take_a, take_b, wb_slot;
  logic [NADD-1:0][AW-1:0] wb_val;
  logic                    pair_any, inflight;
  logic [AW-1:0]           emit_val;

  assign busy = (phase_q != PH_IDLE) || ov_q;
  assign go   = start && !busy;

  // operand storage, written only while idle (R1)
  always_ff @(posedge clk) begin
    if (ld_en && !busy && ld_sel)  mat_q[ld_row][ld_col] <= ld_data;
    if (ld_en && !busy && !ld_sel) vec_q[ld_col]         <= ld_data;
  end

  skadd_mapper #(
    .ROWS(ROWS), .COLS(COLS), .DW(DW), .RW(RW), .CW(CW),
    .BW(BW), .AW(AW), .SW(SW)
  ) u_map (
    .clk(clk), .rst_n(rst_n), .go(go),
    .m_elem(mat_q[map_row][map_col]), .v_elem(vec_q[map_col]),
    .rd_row(map_row), .rd_col(map_col),
    .wr_en(map_wr), .wr_slot(map_slot), .wr_key(map_key), .wr_val(map_val),
    .done(map_done)
  );

  skadd_pool #(
    .NSLOT(NSLOT), .NADD(NADD), .RW(RW), .AW(AW), .SW(SW)
  ) u_pool (
    .clk(clk), .rst_n(rst_n), .clr(go),
    .wr_en(map_wr), .wr_slot(map_slot), .wr_key(map_key), .wr_val(map_val),
    .take_en(take_en), .take_a(take_a), .take_b(take_b),
    .wb_en(wb_en), .wb_slot(wb_slot), .wb_val(wb_val),
    .valid_o(pool_valid), .key_o(pool_key), .val_o(pool_val)
  );

  skadd_dispatch #(
    .ROWS(ROWS), .NSLOT(NSLOT), .NADD(NADD), .RW(RW), .AW(AW), .SW(SW)
  ) u_disp (
    .clk(clk), .rst_n(rst_n), .enable(phase_q == PH_RED),
    .valid(pool_valid), .key(pool_key), .val(pool_val),
    .take_en(take_en), .take_a(take_a), .take_b(take_b),
    .wb_en(wb_en), .wb_slot(wb_slot), .wb_val(wb_val),
    .pair_any(pair_any), .inflight(inflight)
  );

  // the single surviving term for the row being emitted, zero if none (R4)
  always_comb begin
    emit_val = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (pool_valid[s] && (pool_key[s] == row_q)) emit_val = pool_val[s];
    end
  end

  always_comb begin
    phase_d = phase_q;
    row_d   = row_q;
    ov_d    = 1'b0;
    orow_d  = orow_q;
    osum_d  = osum_q;
    case (phase_q)
      PH_IDLE: if (go) phase_d = PH_MAP;
      PH_MAP:  if (map_done) phase_d = PH_RED;
      PH_RED: begin
        if (!pair_any && !inflight) begin
          phase_d = PH_EMIT;
          row_d   = '0;
        end
      end
      PH_EMIT: begin
        ov_d   = 1'b1;
        orow_d = row_q;
        osum_d = emit_val;
        row_d  = row_q + 1'b1;
        if (row_q == RW'(ROWS - 1)) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      row_q   <= '0;
      ov_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      row_q   <= row_d;
      ov_q    <= ov_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ov_d) begin
      orow_q <= orow_d;
      osum_q <= osum_d;
    end
  end

  assign out_valid = ov_q;
  assign out_row   = orow_q;
  assign out_sum   = osum_q;
endmodule

// File: rtl/skadd_checker.sv
module skadd_checker #(
  parameter int NSLOT = 64,
  parameter int RW    = 2,
  parameter int AW    = 10,
  parameter int SW    = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     busy,
  input logic                     out_valid,
  input logic [RW-1:0]            out_row,
  input logic [1:0]               take_en,
  input logic [1:0][SW-1:0]       take_a,
  input logic [1:0][SW-1:0]       take_b,
  input logic [NSLOT-1:0]         pool_valid,
  input logic [NSLOT-1:0][RW-1:0] pool_key,
  input logic [NSLOT-1:0][AW-1:0] pool_val,
  input logic                     pair_any,
  input logic                     inflight,
  input logic                     map_wr,
  input logic [AW-1:0]            map_val
);
  logic [AW:0] wide0, wide1;
  assign wide0 = {1'b0, pool_val[take_a[0]]} + {1'b0, pool_val[take_b[0]]};
  assign wide1 = {1'b0, pool_val[take_a[1]]} + {1'b0, pool_val[take_b[1]]};

  AST_NO_OVERFLOW0: assert property (@(posedge clk) disable iff (!rst_n)
    take_en[0] |-> !wide0[AW]); // R3
  AST_NO_OVERFLOW1: assert property (@(posedge clk) disable iff (!rst_n)
    take_en[1] |-> !wide1[AW]); // R3
  AST_ZERO_TERM_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    map_wr |-> (map_val != '0)); // R4
  AST_PAIR0_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    take_en[0] |-> (pool_valid[take_a[0]] && pool_valid[take_b[0]] &&
                    take_a[0] != take_b[0] &&
                    pool_key[take_a[0]] == pool_key[take_b[0]])); // R7
  AST_PAIR1_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    take_en[1] |-> (pool_valid[take_a[1]] && pool_valid[take_b[1]] &&
                    take_a[1] != take_b[1] &&
                    pool_key[take_a[1]] == pool_key[take_b[1]])); // R7
  AST_DISJOINT_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
    (take_en == 2'b11) |-> (take_a[0] != take_a[1] && take_a[0] != take_b[1] &&
                            take_b[0] != take_a[1] && take_b[0] != take_b[1])); // R7
  AST_SETTLED_BEFORE_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!pair_any && !inflight)); // R8
  AST_FIRST_ROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_row == '0)); // R6
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> (out_row == RW'($past(out_row) + 1'b1))); // R6
  AST_OUT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy); // R6
endmodule

bind skadd_engine skadd_checker #(
  .NSLOT(NSLOT), .RW(RW), .AW(AW), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .out_valid(out_valid),
  .out_row(out_row), .take_en(take_en), .take_a(take_a), .take_b(take_b),
  .pool_valid(pool_valid), .pool_key(pool_key), .pool_val(pool_val),
  .pair_any(pair_any), .inflight(inflight), .map_wr(map_wr), .map_val(map_val)
);

// File: tb/tb_skadd_engine.sv
module tb_skadd_engine;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int DW   = 4;
  localparam int RW   = 2;
  localparam int CW   = 2;
  localparam int AW   = 2 * DW + CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_en = 1'b0, ld_sel = 1'b0, start = 1'b0;
  logic [RW-1:0] ld_row = '0;
  logic [CW-1:0] ld_col = '0;
  logic [DW-1:0] ld_data = '0;
  logic          busy, out_valid;
  logic [RW-1:0] out_row;
  logic [AW-1:0] out_sum;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int m [ROWS][COLS];
  int v [COLS];

  skadd_engine #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_row(ld_row), .ld_col(ld_col), .ld_data(ld_data), .start(start),
    .busy(busy), .out_valid(out_valid), .out_row(out_row), .out_sum(out_sum)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int dot(input int r);
    int s = 0;
    for (int j = 0; j < COLS; j++) s += m[r][j] * v[j];
    return s;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load1(input bit sel, input int r, input int c, input int d);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel; ld_row = RW'(r); ld_col = CW'(c); ld_data = DW'(d);
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic load_all();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) load1(1'b1, r, c, m[r][c]);
    for (int c = 0; c < COLS; c++) load1(1'b0, 0, c, v[c]);
  endtask

  // inj: 0 none, 1 loads while busy, 2 extra start while busy
  task automatic run(input string tag, input int inj);
    int n = 0;
    int t = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({"R2 busy after start ", tag}, int'(busy), 1);
    while (busy && t < 4000) begin
      if (t == 3 && inj == 1) begin
        ld_en = 1'b1; ld_sel = 1'b0; ld_col = '0; ld_data = DW'(7);
      end
      if (t == 4 && inj == 1) begin
        ld_sel = 1'b1; ld_row = '0; ld_col = CW'(1); ld_data = DW'(9);
      end
      if (t == 5) ld_en = 1'b0;
      if (t == 6 && inj == 2) start = 1'b1;
      if (t == 7) start = 1'b0;
      if (out_valid) begin
        check({"R6 row order ", tag}, int'(out_row), n);
        check({"R3 sum ", tag}, int'(out_sum), dot(n));
        n++;
      end
      @(negedge clk);
      t++;
    end
    ld_en = 1'b0;
    start = 1'b0;
    check({"R6 result count ", tag}, n, ROWS);
    repeat (3) begin
      @(negedge clk);
      check({"R2 no extra stream ", tag}, int'(out_valid), 0);
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5a17);
    repeat (3) @(negedge clk);
    check("R9 busy at reset", int'(busy), 0);
    check("R9 out_valid at reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 single set bits and mixed patterns
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) m[r][c] = (r == c) ? 11 : 0;
    v[0] = 6; v[1] = 1; v[2] = 8; v[3] = 15;
    load_all();
    run("R5 diagonal", 0);

    // R4 zero operand column and all-zero row
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) m[r][c] = (r == 2) ? 0 : (r + c + 1);
    v[0] = 3; v[1] = 0; v[2] = 5; v[3] = 9;
    load_all();
    run("R4 zero row", 0);

    // R3 saturated operands
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) m[r][c] = 15;
    for (int c = 0; c < COLS; c++) v[c] = 15;
    load_all();
    run("R3 max", 0);

    // R4 all zero
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) m[r][c] = 0;
    for (int c = 0; c < COLS; c++) v[c] = 0;
    load_all();
    run("R4 all zero", 0);

    // R1 loads while busy are dropped; rerun on kept operands
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) m[r][c] = (r * 3 + c * 5) % 16;
    v[0] = 2; v[1] = 13; v[2] = 4; v[3] = 10;
    load_all();
    run("R1 load during run", 1);
    run("R1 kept operands", 0);

    // R2 start while busy
    run("R2 start during run", 2);

    // random operands with some zeros
    for (int k = 0; k < 12; k++) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          m[r][c] = ($urandom_range(3) == 0) ? 0 : int'($urandom_range(15));
      for (int c = 0; c < COLS; c++)
        v[c] = ($urandom_range(3) == 0) ? 0 : int'($urandom_range(15));
      load_all();
      run("R3 random", 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule